// File: doc/BRIEF.md
# Ones-Complement Adder with Overflow

This block adds two signed words held in ones-complement form, together with a single carry-in bit. It is the shared arithmetic element of a small accumulator machine. The caller uses it for addition, subtraction, increment, and the add phase of multiply-step and divide-step. The caller picks the operands and inverts them where needed. The adder only adds what it is given.

Subtraction drives the second operand with the bitwise complement of the subtrahend and takes the raw sum. Increment feeds the constant 1 on one side. A divide-step pass feeds either the memory word, or its complement with the carry-in set. Addition takes the clean sum, so an add never returns negative zero.

The arithmetic core is purely combinational. A parameter can place one register stage on the outputs, which is used where results must line up with a clock. The sign of a word is its most significant bit, `op_a[W-1]`.

Top module: `oc_adder`

## Requirements
- R1: With W bits, `sum_raw` equals op_a + op_b + carry_in, reduced by repeatedly adding every bit above position W-1 back into the low W bits until the value fits in W bits.
- R2: The carry out of the sign bit is added back into bit 0 (end-around). When op_a and op_b are both all ones and carry_in is 1, `sum_raw` is 000...001.
- R3: `ovf` is 1 exactly when op_a[W-1] equals op_b[W-1] and sum_raw[W-1] differs from them. Example: 0111...1 + 000...0 with carry_in 1 sets `ovf`.
- R4: `sum_clean` equals `sum_raw`, except that an all-ones `sum_raw` (negative zero) gives all zeros. `sum_clean` is never all ones.
- R5: For any x, adding x to ~x with carry_in 0 gives an all-ones `sum_raw`, an all-zero `sum_clean` and `ovf` 0.
- R6: With op_b zero and carry_in 0, `sum_raw` equals op_a. This includes an all-ones op_a, which stays all ones on `sum_raw`.
- R7: With OUT_REG=1 (default), every output shows the result of the inputs sampled at the previous rising clock edge. It does not change before that edge. While rst_n is 0, all outputs are 0.
- R8: Subtraction done as op_a + ~m gives op_a minus m. +0 minus +0 gives all ones on `sum_raw` and zero on `sum_clean`. The divide-step form op_a + ~m with carry_in 1 follows the R1 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | W | First operand, ones-complement, MSB is sign |
| op_b | input | W | Second operand, ones-complement, MSB is sign |
| carry_in | input | 1 | Extra unit added to the sum |
| sum_raw | output | W | End-around-carry sum, may be negative zero |
| sum_clean | output | W | Sum with negative zero turned into positive zero |
| ovf | output | 1 | Ones-complement overflow |

## Verification
Several kinds of operands are driven, and each tests a different part of the block:
- Signed zeros of both kinds (+0 and -0), and a word added to its own complement, test the negative-zero clean-up, which has no effect on other values.
- Extreme magnitudes, such as the largest positive word plus one and the most negative word plus a negative value, test overflow in both directions.
- The double all-ones case with carry-in set is the only input that makes the end-around carry ripple a second time.
- Subtract-form and divide-step-form operands, plus many random words, compare every output with a model of the same sums done in integers.

// File: rtl/oc_pkg.sv
package oc_pkg;

   typedef enum logic [0:0] {
      OC_CARRY_BEHAV  = 1'b0,
      OC_CARRY_RIPPLE = 1'b1
   } oc_carry_e;

   function automatic logic fa_sum(input logic x, input logic y, input logic c);
      return x ^ y ^ c;
   endfunction

   function automatic logic fa_carry(input logic x, input logic y, input logic c);
      return (x & y) | (x & c) | (y & c);
   endfunction

endpackage

// File: rtl/oc_add_stage.sv
module oc_add_stage #(
   parameter int W = 18,
   parameter oc_pkg::oc_carry_e STYLE = oc_pkg::OC_CARRY_RIPPLE
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);

   generate
      if (STYLE == oc_pkg::OC_CARRY_RIPPLE) begin : g_ripple
         logic [W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign s[i]         = oc_pkg::fa_sum(x[i], y[i], chain[i]);
            assign chain[i + 1] = oc_pkg::fa_carry(x[i], y[i], chain[i]);
         end
         assign cout = chain[W];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign s    = wide[W-1:0];
         assign cout = wide[W];
      end
   endgenerate

endmodule

// File: rtl/oc_sign_flags.sv
module oc_sign_flags #(
   parameter int W = 18
) (
   input  logic         sign_a,
   input  logic         sign_b,
   input  logic [W-1:0] raw,
   output logic [W-1:0] clean,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic neg_zero;
   logic same_sign;

   assign neg_zero  = &raw;
   assign same_sign = ~(sign_a ^ sign_b);
   assign ovf       = same_sign & (raw[MSB] ^ sign_a);
   assign clean     = neg_zero ? '0 : raw;

endmodule

// File: rtl/oc_out_stage.sv
module oc_out_stage #(
   parameter int W      = 18,
   parameter bit ENABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_d,
   input  logic [W-1:0] clean_d,
   input  logic         ovf_d,
   output logic [W-1:0] raw_q,
   output logic [W-1:0] clean_q,
   output logic         ovf_q
);

   generate
      if (ENABLE) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               raw_q   <= '0;
               clean_q <= '0;
               ovf_q   <= 1'b0;
            end else begin
               raw_q   <= raw_d;
               clean_q <= clean_d;
               ovf_q   <= ovf_d;
            end
         end
      end else begin : g_pass
         assign raw_q   = raw_d;
         assign clean_q = clean_d;
         assign ovf_q   = ovf_d;
      end
   endgenerate

endmodule

// File: rtl/oc_adder.sv
module oc_adder #(
   parameter int W = 18,
   parameter oc_pkg::oc_carry_e CARRY_STYLE = oc_pkg::OC_CARRY_RIPPLE,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         carry_in,
   output logic [W-1:0] sum_raw,
   output logic [W-1:0] sum_clean,
   output logic         ovf
);

   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("oc_adder: W must be at least 2");
      end
   endgenerate

   // first pass: operands plus carry-in
   logic [W-1:0] pass1_s;
   logic         pass1_c;
   // second pass: end-around carry folded back into bit 0
   logic [W-1:0] pass2_s;
   logic         pass2_c;
   logic [W-1:0] raw_c;
   logic [W-1:0] clean_c;
   logic         ovf_c;

   oc_add_stage #(.W(W), .STYLE(CARRY_STYLE)) u_pass1 (
      .x    (op_a),
      .y    (op_b),
      .cin  (carry_in),
      .s    (pass1_s),
      .cout (pass1_c)
   );

   oc_add_stage #(.W(W), .STYLE(CARRY_STYLE)) u_pass2 (
      .x    (pass1_s),
      .y    ('0),
      .cin  (pass1_c),
      .s    (pass2_s),
      .cout (pass2_c)
   );

   // a second wrap only happens from an all-ones pass1 word, leaving pass2_s zero
   assign raw_c = {pass2_s[MSB:1], pass2_s[0] | pass2_c};

   oc_sign_flags #(.W(W)) u_flags (
      .sign_a (op_a[MSB]),
      .sign_b (op_b[MSB]),
      .raw    (raw_c),
      .clean  (clean_c),
      .ovf    (ovf_c)
   );

   oc_out_stage #(.W(W), .ENABLE(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_d   (raw_c),
      .clean_d (clean_c),
      .ovf_d   (ovf_c),
      .raw_q   (sum_raw),
      .clean_q (sum_clean),
      .ovf_q   (ovf)
   );

endmodule

// File: rtl/oc_adder_chk.sv
module oc_adder_chk #(
   parameter int W   = 18,
   parameter bit LAT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic         carry_in,
   input logic [W-1:0] sum_raw,
   input logic [W-1:0] sum_clean,
   input logic         ovf
);

   localparam int MSB = W - 1;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] a_al;
   logic [W-1:0] b_al;
   logic         ci_al;
   logic         seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   generate
      if (LAT) begin : g_lat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_al  <= '0;
               b_al  <= '0;
               ci_al <= 1'b0;
            end else begin
               a_al  <= op_a;
               b_al  <= op_b;
               ci_al <= carry_in;
            end
         end
      end else begin : g_comb
         assign a_al  = op_a;
         assign b_al  = op_b;
         assign ci_al = carry_in;
      end
   endgenerate

   assert_double_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && a_al == ONES && b_al == ONES && ci_al) |-> (sum_raw == ONE));

   assert_overflow_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (ovf == ((a_al[MSB] == b_al[MSB]) && (sum_raw[MSB] != a_al[MSB]))));

   assert_clean_never_negzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (sum_clean != ONES));

   assert_clean_tracks_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ((sum_raw == ONES) ? (sum_clean == '0) : (sum_clean == sum_raw)));

   assert_complement_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && b_al == ~a_al && !ci_al) |-> (sum_raw == ONES && !ovf));

   assert_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && b_al == '0 && !ci_al) |-> (sum_raw == a_al));

endmodule

bind oc_adder oc_adder_chk #(.W(W), .LAT(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sum_raw   (sum_raw),
   .sum_clean (sum_clean),
   .ovf       (ovf)
);

// File: tb/tb_oc_adder.sv
module tb_oc_adder;

   localparam int W        = 18;
   localparam int CLK_PER  = 10;
   localparam int WATCHDOG = 20000;
   localparam logic [W-1:0] ONES    = '1;
   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   typedef struct {
      logic [W-1:0] raw;
      logic [W-1:0] clean;
      logic         ov;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum_raw;
   logic [W-1:0] sum_clean;
   logic         ovf;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   exp_t pend[$];

   oc_adder #(.W(W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum_raw   (sum_raw),
      .sum_clean (sum_clean),
      .ovf       (ovf)
   );

   always #(CLK_PER / 2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog R7 actual cycles=%0d expected below %0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // integer reference: fold high part back until it fits
   function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic ci, input string tag);
      exp_t e;
      longint mask = (longint'(1) << W) - 1;
      longint v = longint'(a) + longint'(b) + longint'(ci);
      while (v > mask) v = (v & mask) + (v >> W);
      e.raw   = v[W-1:0];
      e.clean = (e.raw == ONES) ? '0 : e.raw;
      e.ov    = (a[W-1] == b[W-1]) && (e.raw[W-1] != a[W-1]);
      e.tag   = tag;
      return e;
   endfunction

   task automatic check(input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
      end
   endtask

   task automatic compare_front();
      exp_t e;
      if (pend.size() > 0) begin
         e = pend.pop_front();
         check(e.tag, "sum_raw", sum_raw, e.raw);
         check(e.tag, "sum_clean", sum_clean, e.clean);
         check(e.tag, "ovf", ovf, e.ov);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input string tag);
      @(negedge clk);
      compare_front();
      op_a     = a;
      op_b     = b;
      carry_in = ci;
      pend.push_back(model(a, b, ci, tag));
   endtask

   task automatic flush();
      @(negedge clk);
      compare_front();
   endtask

   initial begin
      logic [W-1:0] held;
      // R7: reset state
      op_a = 18'o123456;
      op_b = 18'o054321;
      repeat (3) @(negedge clk);
      check("R7", "reset sum_raw", sum_raw, 0);
      check("R7", "reset sum_clean", sum_clean, 0);
      check("R7", "reset ovf", ovf, 0);
      rst_n = 1'b1;
      op_a  = '0;
      op_b  = '0;

      // R8 / R4: +0 + -0 and +0 minus +0
      apply('0, ONES, 1'b0, "R4");
      apply('0, ~18'o0, 1'b0, "R8");
      // R3: max positive + 1, and overflow via carry-in
      apply(MAX_POS, ONE, 1'b0, "R3");
      apply(MAX_POS, '0, 1'b1, "R3");
      // R3: negative overflow
      apply(18'o400000, 18'o600000, 1'b0, "R3");
      // R5: x + ~x
      apply(18'o123456, ~18'o123456, 1'b0, "R5");
      apply(18'o000777, ~18'o000777, 1'b0, "R5");
      // R2: end-around carry, single and double wrap
      apply(18'o777776, 18'o000003, 1'b0, "R2");
      apply(ONES, ONES, 1'b1, "R2");
      // R6: identity including -0
      apply(18'o246135, '0, 1'b0, "R6");
      apply(ONES, '0, 1'b0, "R6");
      // R1: increment
      apply(ONE, 18'o000777, 1'b0, "R1");
      // R8: subtract and divide-step form
      apply(18'o000100, ~18'o000025, 1'b0, "R8");
      apply(18'o000025, ~18'o000100, 1'b0, "R8");
      apply(18'o000100, ~18'o000025, 1'b1, "R8");
      // R1: random words
      for (int i = 0; i < 300; i++) begin
         apply(W'($urandom), W'($urandom), 1'($urandom), "R1");
      end
      flush();

      // R7: output holds until the next rising edge
      apply(18'o000005, 18'o000002, 1'b0, "R7");
      flush();
      held = sum_raw;
      @(negedge clk);
      op_a = 18'o000070;
      op_b = 18'o000001;
      #1;
      check("R7", "hold before edge", sum_raw, held);
      @(negedge clk);
      check("R7", "update after edge", sum_raw, 18'o000071);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule